// File: doc/BRIEF.md
# Display-Enable Boundary Sampler

This block turns a horizontal "display window" flag into the display-enable strobe used by the video fetch path. The flag alone does not drive the strobe. It is looked at only on a short, fixed list of line-cycle positions, and only there can the strobe rise or fall. As a result, every line start and line end lands on one of a handful of known positions, whatever jitter the flag has. These positions are the same in every clock-phase alignment between processor and video logic.

The block receives the current line cycle, the window flag, a line-restart pulse and a variant pin. The variant pin selects the early-start variant, which fetches one word group ahead to allow fine horizontal scrolling. The block outputs the registered display-enable. It also reports, once per line, how many bytes the line fetched: half the number of cycles for which display-enable was high. This byte count holds until the next restart.

Top module: `de_boundary_sampler`

## Requirements
- R1: While reset (`rst_n` low) is applied and after it is released, `de` is 0 and `line_bytes` is 0 until the first line end.
- R2: With `early_sel` = 0, if `h_flag` is 1 while `cyc` is 8, 56 or 60, then `de` is 1 from the next cycle.
- R3: With `early_sel` = 1, the rising positions are 8, 40, 44 and 60. Cycle 56 then has no effect, and cycles 40 and 44 have no effect when `early_sel` = 0.
- R4: If `h_flag` is 0 while `cyc` is 168, 376 or 380, then `de` is 0 from the next cycle.
- R5: If `h_flag` is 1 while `cyc` is 468, then `de` is 0 from the next cycle. If `h_flag` is 0 at cycle 468, `de` is left as it was.
- R6: On every cycle value not listed in R2 to R5, `de` keeps its value, whatever `h_flag` does.
- R7: A cycle with `line_restart` = 1 makes `de` 0 from the next cycle. This takes priority over any rising position.
- R8: On `line_restart`, `line_bytes` takes half the number of cycles during which `de` was 1 in the line just ended, that cycle included. So a rise at position a and a fall at position b give (b-a)/2: 60 to 380 gives 160, 8 to 376 gives 184, 56 to 468 gives 206.
- R9: `line_bytes` changes only on a cycle that follows `line_restart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-side clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_restart | input | 1 | One-cycle pulse on the last cycle of a line |
| cyc | input | CNT_W | Current line cycle position |
| h_flag | input | 1 | Horizontal display window flag |
| early_sel | input | 1 | 1 selects the early-start (scroll) variant |
| de | output | 1 | Registered display-enable |
| line_bytes | output | CNT_W | Bytes fetched by the last completed line |

## Verification
The bench builds the block with its default parameters: a 9-bit cycle position and the boundary positions listed above. It runs 512-cycle lines, plus one 300-cycle line cut short by an early restart. With these widths, every boundary, including the sync-side clear at 468, falls inside the line. The longest possible fetch, 251 bytes, also fits in the byte count. Windows that open or close between boundaries, at boundaries and past 468 reach every quantisation outcome in both variants. Lines with a per-cycle random window flag check that non-boundary cycles leave `de` alone.

// File: rtl/de_boundary_sampler.sv
module de_boundary_sampler #(
  parameter int CNT_W      = 9,
  parameter int ON_LEFT    = 8,
  parameter int ON_EARLY_A = 40,
  parameter int ON_EARLY_B = 44,
  parameter int ON_STD     = 56,
  parameter int ON_LATE    = 60,
  parameter int OFF_MID    = 168,
  parameter int OFF_SHORT  = 376,
  parameter int OFF_LONG   = 380,
  parameter int OFF_SYNC   = 468
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_restart,
  input  logic [CNT_W-1:0] cyc,
  input  logic             h_flag,
  input  logic             early_sel,
  output logic             de,
  output logic [CNT_W-1:0] line_bytes
);
  localparam int RUN_W = CNT_W + 1;

  logic             de_q;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_total;
  logic [CNT_W-1:0] bytes_q;

  wire at_left    = cyc == CNT_W'(ON_LEFT);
  wire at_early_a = cyc == CNT_W'(ON_EARLY_A);
  wire at_early_b = cyc == CNT_W'(ON_EARLY_B);
  wire at_std     = cyc == CNT_W'(ON_STD);
  wire at_late    = cyc == CNT_W'(ON_LATE);
  wire at_mid     = cyc == CNT_W'(OFF_MID);
  wire at_short   = cyc == CNT_W'(OFF_SHORT);
  wire at_long    = cyc == CNT_W'(OFF_LONG);
  wire at_sync    = cyc == CNT_W'(OFF_SYNC);

  wire variant_on = early_sel ? (at_early_a | at_early_b) : at_std;
  wire set_req    = h_flag & (at_left | at_late | variant_on);
  wire clr_req    = (~h_flag & (at_mid | at_short | at_long)) | (h_flag & at_sync);

  assign run_total = run_q + RUN_W'(de_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            de_q <= 1'b0;
    else if (line_restart) de_q <= 1'b0;
    else if (set_req)      de_q <= 1'b1;
    else if (clr_req)      de_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      bytes_q <= '0;
    end else if (line_restart) begin
      run_q   <= '0;
      bytes_q <= run_total[RUN_W-1:1];
    end else begin
      run_q   <= run_total;
    end
  end

  assign de         = de_q;
  assign line_bytes = bytes_q;
endmodule

module de_boundary_sampler_chk #(
  parameter int CNT_W      = 9,
  parameter int ON_LEFT    = 8,
  parameter int ON_EARLY_A = 40,
  parameter int ON_EARLY_B = 44,
  parameter int ON_STD     = 56,
  parameter int ON_LATE    = 60,
  parameter int OFF_MID    = 168,
  parameter int OFF_SHORT  = 376,
  parameter int OFF_LONG   = 380,
  parameter int OFF_SYNC   = 468
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_restart,
  input logic [CNT_W-1:0] cyc,
  input logic             h_flag,
  input logic             early_sel,
  input logic             de,
  input logic [CNT_W-1:0] line_bytes
);
  wire on_edge  = cyc == CNT_W'(ON_LEFT) || cyc == CNT_W'(ON_LATE) || cyc == CNT_W'(ON_STD) ||
                  cyc == CNT_W'(ON_EARLY_A) || cyc == CNT_W'(ON_EARLY_B);
  wire off_edge = cyc == CNT_W'(OFF_MID) || cyc == CNT_W'(OFF_SHORT) ||
                  cyc == CNT_W'(OFF_LONG) || cyc == CNT_W'(OFF_SYNC);

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!de && line_bytes == '0)); // R1
  AST_SET_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_restart && h_flag && (cyc == CNT_W'(ON_LEFT) || cyc == CNT_W'(ON_LATE))) |=> de); // R2
  AST_SET_STD: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_restart && h_flag && !early_sel && cyc == CNT_W'(ON_STD)) |=> de); // R2
  AST_SET_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_restart && h_flag && early_sel &&
     (cyc == CNT_W'(ON_EARLY_A) || cyc == CNT_W'(ON_EARLY_B))) |=> de); // R3
  AST_CLR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_flag && (cyc == CNT_W'(OFF_MID) || cyc == CNT_W'(OFF_SHORT) || cyc == CNT_W'(OFF_LONG)))
    |=> !de); // R4
  AST_CLR_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (h_flag && cyc == CNT_W'(OFF_SYNC)) |=> !de); // R5
  AST_HOLD_ELSEWHERE: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_restart && !on_edge && !off_edge) |=> $stable(de)); // R6
  AST_RESTART_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    line_restart |=> !de); // R7
  AST_BYTES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !line_restart |=> $stable(line_bytes)); // R9
endmodule

bind de_boundary_sampler de_boundary_sampler_chk #(
  .CNT_W(CNT_W), .ON_LEFT(ON_LEFT), .ON_EARLY_A(ON_EARLY_A), .ON_EARLY_B(ON_EARLY_B),
  .ON_STD(ON_STD), .ON_LATE(ON_LATE), .OFF_MID(OFF_MID), .OFF_SHORT(OFF_SHORT),
  .OFF_LONG(OFF_LONG), .OFF_SYNC(OFF_SYNC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .line_restart(line_restart), .cyc(cyc), .h_flag(h_flag),
  .early_sel(early_sel), .de(de), .line_bytes(line_bytes)
);

// File: tb/de_boundary_sampler_tb.sv
`timescale 1ns/1ps
module de_boundary_sampler_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_restart = 1'b0;
  logic [8:0] cyc = '0;
  logic       h_flag = 1'b0;
  logic       early_sel = 1'b0;
  logic       de;
  logic [8:0] line_bytes;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit m_de = 1'b0;
  int m_run = 0;
  int m_bytes = 0;

  always #10 clk = ~clk;

  de_boundary_sampler dut_i (
    .clk(clk), .rst_n(rst_n), .line_restart(line_restart), .cyc(cyc),
    .h_flag(h_flag), .early_sel(early_sel), .de(de), .line_bytes(line_bytes)
  );

  function automatic bit next_de(bit d, int c, bit h, bit e, bit rs);
    if (rs) return 1'b0;
    if (h && (c == 8 || c == 60 || (!e && c == 56) || (e && (c == 40 || c == 44)))) return 1'b1;
    if (!h && (c == 168 || c == 376 || c == 380)) return 1'b0;
    if (h && c == 468) return 1'b0;
    return d;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_line(int on, int off, bit e, int len, bit rnd_h, int exp_bytes, string req);
    int bad_cyc = -1;
    int bad_act = 0;
    int prev_bytes = m_bytes;
    for (int c = 0; c < len; c++) begin
      bit h = rnd_h ? bit'($urandom_range(0, 1)) : (c >= on && c < off);
      bit rs = (c == len - 1);
      cyc = 9'(c);
      h_flag = h;
      early_sel = e;
      line_restart = rs;
      @(posedge clk);
      @(negedge clk);
      m_run += int'(m_de);
      m_de = next_de(m_de, c, h, e, rs);
      if (rs) begin
        m_bytes = m_run / 2;
        m_run = 0;
      end
      if (de !== m_de && bad_cyc < 0) begin
        bad_cyc = c;
        bad_act = int'(de);
      end
      if (c == len / 2) check(int'(line_bytes) == prev_bytes, "R9 bytes held mid-line",
                              int'(line_bytes), prev_bytes);
    end
    check(bad_cyc < 0, {req, " de trace (cycle of first mismatch as actual)"}, bad_cyc, -1);
    check(int'(line_bytes) == m_bytes, {req, " line bytes vs model"}, int'(line_bytes), m_bytes);
    if (exp_bytes >= 0)
      check(int'(line_bytes) == exp_bytes, {req, " line bytes"}, int'(line_bytes), exp_bytes);
    check(de == 1'b0, "R7 de low after restart", int'(de), 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(de == 1'b0, "R1 de in reset", int'(de), 0);
    check(line_bytes == 9'd0, "R1 bytes in reset", int'(line_bytes), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(de == 1'b0 && line_bytes == 9'd0, "R1 after release", int'(de), 0);

    run_line(58, 379, 1'b0, 512, 1'b0, 160, "R8 R2 R4 late on 60 off 380");
    run_line(0, 376, 1'b0, 512, 1'b0, 184, "R8 R2 R4 on 8 off 376");
    run_line(10, 600, 1'b0, 512, 1'b0, 206, "R8 R5 on 56 off 468");
    run_line(0, 600, 1'b0, 512, 1'b0, 230, "R5 R2 on 8 off 468");
    run_line(58, 160, 1'b0, 512, 1'b0, 54, "R4 off at 168");
    run_line(50, 380, 1'b0, 512, 1'b0, 162, "R2 R4 on 56 off 380");
    run_line(100, 600, 1'b0, 512, 1'b0, 0, "R6 window opens after last rise");
    run_line(38, 600, 1'b1, 512, 1'b0, 214, "R3 early rise at 40");
    run_line(42, 600, 1'b1, 512, 1'b0, 212, "R3 early rise at 44");
    run_line(38, 600, 1'b0, 512, 1'b0, 206, "R3 40 ignored in standard");
    run_line(50, 600, 1'b1, 512, 1'b0, 204, "R3 56 ignored in early");
    run_line(0, 400, 1'b0, 512, 1'b0, 251, "R5 low h at 468 leaves de");
    run_line(0, 600, 1'b0, 300, 1'b0, 145, "R7 R8 short line restart");

    for (int n = 0; n < 20; n++) begin
      int on = $urandom_range(0, 120);
      int off = on + $urandom_range(0, 480);
      run_line(on, off, bit'($urandom_range(0, 1)), 512, 1'b0, -1, "R2 R3 R4 R5 random window");
    end
    for (int n = 0; n < 8; n++)
      run_line(0, 0, bit'($urandom_range(0, 1)), 512, 1'b1, -1, "R6 random h per cycle");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule